// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block sits next to a DRAM controller and decides when refresh cycles are run. A free-running interval timer adds one owed refresh each time it expires. While any refresh is owed, the block raises a request toward the controller. The controller answers with a grant when it has finished any access already in progress, and with a done when the CAS-before-RAS cycle has completed. Each completed refresh retires one owed entry and advances a sweep counter. That counter reports when a full pass over every row has been made.

The block also runs a controlled trip into and out of self refresh. An entry request is honoured only once a full row sweep has completed since the last exit, and only while no refresh is in flight. Entry and exit are each bracketed by a forced refresh. The first forced refresh runs just before the RAS hold begins. The hold then lasts at least a minimum time, which keeps the device clear of the forbidden transition window. Once the hold drops, a longer precharge wait follows before the second forced refresh. Leaving self refresh clears the sweep counter, and the interval timer starts again from zero.

Top module: `ref_refresh_sched`

## Requirements
- R1: While reset is asserted, ref_req, sr_hold, host_stall and sweep_done are all low.
- R2: In normal mode an owed refresh is added every INTERVAL_CYC clock cycles. The first ref_req rises exactly INTERVAL_CYC cycles after reset is released.
- R3: The owed count saturates at OWED_MAX. Each completed refresh in normal mode retires exactly one owed entry.
- R4: ref_req stays high until ref_gnt is seen, and stays low while that refresh is in flight. A ref_gnt while ref_req is low has no effect. A ref_done with no refresh in flight has no effect.
- R5: host_stall is high whenever ref_req is high, whenever a refresh is in flight, and whenever the block is outside normal mode.
- R6: Completed refreshes are counted up to SWEEP_ROWS. sweep_done goes high on the completion that reaches SWEEP_ROWS.
- R7: sr_enter_req is ignored unless sweep_done is high and no refresh is in flight.
- R8: An accepted entry raises ref_req on the next cycle, whatever the owed count. sr_hold rises only in the cycle after that refresh's done.
- R9: sr_hold stays high for at least SR_MIN_CYC cycles. It falls one cycle after both sr_exit_req is high and the minimum has been served.
- R10: After sr_hold falls, ref_req stays low for exactly SR_PRE_CYC cycles and then rises for the exit refresh. That refresh's done returns the block to normal mode.
- R11: Leaving self refresh clears the sweep count, and the exit refresh counts as the first completion. On the return to normal mode, the owed count is zero and the interval timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| sr_enter_req | input | 1 | Request to enter self refresh |
| sr_exit_req | input | 1 | Request to leave self refresh (level) |
| ref_gnt | input | 1 | Controller has started the requested refresh |
| ref_done | input | 1 | Controller has finished the refresh in flight |
| ref_req | output | 1 | Refresh cycle wanted |
| sr_hold | output | 1 | Hold RAS low for self refresh |
| host_stall | output | 1 | Controller must not start a new host access |
| sweep_done | output | 1 | Full row sweep completed since last self-refresh exit |

## Verification
The bench measures the interval exactly, one cycle early and on the cycle itself. A timer that is off by one would show ref_req one cycle too soon or too late. It lets refreshes pile up until the owed count saturates, then retires them. A counter that wraps would yield far fewer or more grants than OWED_MAX. It sends a stray done and a stray grant and tries to enter self refresh one refresh short of a full sweep. A design that counts unrequested completions would then enter self refresh early. It times the RAS hold with the exit request asserted both early and late, and it times the precharge gap. It repeats the entry attempt straight after exit, which a design that fails to clear the sweep count would wrongly accept.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
  typedef enum logic [2:0] {
    ST_NORM    = 3'd0,
    ST_PRE_ENT = 3'd1,
    ST_SR      = 3'd2,
    ST_SR_PRE  = 3'd3,
    ST_POST    = 3'd4
  } sr_state_t;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CYC = 3120,
  parameter int OWED_MAX     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic retire,
  output logic owed_nz
);
  localparam int CW = $clog2(INTERVAL_CYC);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);
  localparam logic [OW-1:0] OMAX = OW'(OWED_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick, inc, dec;

  always_comb begin
    tick   = (cnt_q == LAST);
    inc    = tick && ((owed_q != OMAX) || retire);
    dec    = retire && (owed_q != '0);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    owed_d = owed_q;
    if (inc && !dec)      owed_d = owed_q + 1'b1;
    else if (dec && !inc) owed_d = owed_q - 1'b1;
    if (!run) begin
      cnt_d  = '0;
      owed_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      owed_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      owed_q <= owed_d;
    end
  end

  assign owed_nz = (owed_q != '0);

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OMAX); // R3
  AST_OWED_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> owed_q == '0); // R11
endmodule

// File: rtl/ref_sweep_counter.sv
module ref_sweep_counter #(
  parameter int SWEEP_ROWS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic done
);
  localparam int SW = $clog2(SWEEP_ROWS + 1);
  localparam logic [SW-1:0] FULL = SW'(SWEEP_ROWS);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    en    = clear || (step && (cnt_q != FULL));
    cnt_d = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == FULL);

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R6
  AST_SWEEP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !done); // R11
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
  import ref_sched_pkg::*;
#(
  parameter int SR_MIN_CYC = 20000,
  parameter int SR_PRE_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed_nz,
  input  logic sweep_done,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  input  logic ref_gnt,
  input  logic ref_done,
  output logic ref_req,
  output logic sr_hold,
  output logic host_stall,
  output logic run_timer,
  output logic retire,
  output logic step,
  output logic sweep_clear
);
  localparam int TMAX = (SR_MIN_CYC > SR_PRE_CYC) ? SR_MIN_CYC : SR_PRE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] MIN_LAST = TW'(SR_MIN_CYC - 1);
  localparam logic [TW-1:0] PRE_LAST = TW'(SR_PRE_CYC - 1);
  localparam logic [TW-1:0] T_SAT    = TW'(TMAX);

  sr_state_t     state_q, state_d;
  logic          inflight_q, inflight_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          take, fin, forced;

  always_comb begin
    forced  = (state_q == ST_PRE_ENT) || (state_q == ST_POST);
    ref_req = !inflight_q && ((state_q == ST_NORM) ? owed_nz : forced);
    take    = ref_req && ref_gnt;
    fin     = inflight_q && ref_done;
    inflight_d = inflight_q;
    if (take)     inflight_d = 1'b1;
    else if (fin) inflight_d = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORM:    if (sr_enter_req && sweep_done && !inflight_q) state_d = ST_PRE_ENT;
      ST_PRE_ENT: if (fin) state_d = ST_SR;
      ST_SR:      if (sr_exit_req && (tcnt_q >= MIN_LAST)) state_d = ST_SR_PRE;
      ST_SR_PRE:  if (tcnt_q >= PRE_LAST) state_d = ST_POST;
      ST_POST:    if (fin) state_d = ST_NORM;
      default:    state_d = ST_NORM;
    endcase
  end

  always_comb begin
    tcnt_d = tcnt_q;
    if (state_d != state_q)
      tcnt_d = '0;
    else if (((state_q == ST_SR) || (state_q == ST_SR_PRE)) && (tcnt_q != T_SAT))
      tcnt_d = tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_NORM;
      inflight_q <= 1'b0;
      tcnt_q     <= '0;
    end else begin
      state_q    <= state_d;
      inflight_q <= inflight_d;
      tcnt_q     <= tcnt_d;
    end
  end

  assign sr_hold     = (state_q == ST_SR);
  assign host_stall  = ref_req || inflight_q || (state_q != ST_NORM);
  assign run_timer   = (state_q == ST_NORM);
  assign retire      = fin && (state_q == ST_NORM);
  assign step        = fin;
  assign sweep_clear = (state_q == ST_SR) && (state_d == ST_SR_PRE);

  AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_gnt |=> ref_req); // R4
  AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !ref_req); // R4
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_hold || state_q == ST_SR_PRE) |-> !ref_req); // R10
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_hold) |-> $past(tcnt_q) >= MIN_LAST); // R9
  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE_ENT && $past(state_q) == ST_NORM) |-> $past(sweep_done)); // R7
  AST_HOLD_AFTER_BRACKET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_hold) |-> ($past(state_q) == ST_PRE_ENT) && $past(ref_done)); // R8
  AST_STALL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req || inflight_q) |-> host_stall); // R5
endmodule

// File: rtl/ref_refresh_sched.sv
module ref_refresh_sched #(
  parameter int INTERVAL_CYC = 3120,
  parameter int OWED_MAX     = 8,
  parameter int SWEEP_ROWS   = 512,
  parameter int SR_MIN_CYC   = 20000,
  parameter int SR_PRE_CYC   = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  input  logic ref_gnt,
  input  logic ref_done,
  output logic ref_req,
  output logic sr_hold,
  output logic host_stall,
  output logic sweep_done
);
  logic owed_nz, run_timer, retire, step, sweep_clear;

  ref_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .OWED_MAX    (OWED_MAX)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_timer),
    .retire (retire),
    .owed_nz(owed_nz)
  );

  ref_sweep_counter #(
    .SWEEP_ROWS(SWEEP_ROWS)
  ) u_sweep (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(sweep_clear),
    .step (step),
    .done (sweep_done)
  );

  sr_fsm #(
    .SR_MIN_CYC(SR_MIN_CYC),
    .SR_PRE_CYC(SR_PRE_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .owed_nz     (owed_nz),
    .sweep_done  (sweep_done),
    .sr_enter_req(sr_enter_req),
    .sr_exit_req (sr_exit_req),
    .ref_gnt     (ref_gnt),
    .ref_done    (ref_done),
    .ref_req     (ref_req),
    .sr_hold     (sr_hold),
    .host_stall  (host_stall),
    .run_timer   (run_timer),
    .retire      (retire),
    .step        (step),
    .sweep_clear (sweep_clear)
  );
endmodule

// File: tb/test_ref_refresh_sched.sv
`timescale 1ns/1ps
module test_ref_refresh_sched;
  localparam int INTV = 20;
  localparam int OMAX = 4;
  localparam int SWP  = 8;
  localparam int SMIN = 30;
  localparam int SPRE = 5;

  logic clk = 1'b0;
  logic rst_n, sr_enter_req, sr_exit_req, ref_gnt, ref_done;
  logic ref_req, sr_hold, host_stall, sweep_done;
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  ref_refresh_sched #(
    .INTERVAL_CYC(INTV), .OWED_MAX(OMAX), .SWEEP_ROWS(SWP),
    .SR_MIN_CYC(SMIN), .SR_PRE_CYC(SPRE)
  ) i_ref_refresh_sched (
    .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .ref_gnt(ref_gnt), .ref_done(ref_done),
    .ref_req(ref_req), .sr_hold(sr_hold), .host_stall(host_stall),
    .sweep_done(sweep_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    ref_gnt = 1'b0; ref_done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic service(input bit chk);
    ref_gnt = 1'b1; tick(); ref_gnt = 1'b0;
    if (chk) begin
      check("R4 req low in flight", ref_req, 0);
      check("R5 stall in flight", host_stall, 1);
    end
    ref_done = 1'b1; tick(); ref_done = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 200 && !ref_req; i++) tick();
  endtask

  task automatic fill_sweep();
    for (int i = 0; i < SWP; i++) begin wait_req(); service(0); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    ref_gnt = 1'b0; ref_done = 1'b0;
    tick();
    check("R1 ref_req", ref_req, 0);
    check("R1 sr_hold", sr_hold, 0);
    check("R1 host_stall", host_stall, 0);
    check("R1 sweep_done", sweep_done, 0);
  endtask

  task automatic t_interval();
    do_reset();
    repeat (INTV - 1) tick();
    check("R2 no req one cycle early", ref_req, 1'b0);
    tick();
    check("R2 req on interval", ref_req, 1);
    check("R5 stall with req", host_stall, 1);
    service(1);
    check("R3 retired", ref_req, 0);
    check("R5 stall cleared", host_stall, 0);
    repeat (INTV - 3) tick();
    check("R2 second interval early", ref_req, 0);
    tick();
    check("R2 second interval", ref_req, 1);
  endtask

  task automatic t_strays();
    do_reset();
    ref_done = 1'b1; tick(); ref_done = 1'b0;
    ref_gnt = 1'b1; tick(); ref_gnt = 1'b0;
    check("R4 stray gnt no stall", host_stall, 0);
    repeat (INTV - 3) tick();
    check("R4 strays keep timing early", ref_req, 0);
    tick();
    check("R4 strays keep timing", ref_req, 1);
  endtask

  task automatic t_saturate();
    int n;
    do_reset();
    repeat (105) tick();
    n = 0;
    for (int i = 0; i < 10 && ref_req; i++) begin service(0); n++; end
    check("R3 owed saturation count", n, OMAX);
  endtask

  task automatic t_sweep();
    do_reset();
    for (int i = 0; i < SWP - 1; i++) begin wait_req(); service(0); end
    ref_done = 1'b1; tick(); ref_done = 1'b0;
    check("R6 not done one short", sweep_done, 0);
    sr_enter_req = 1'b1; tick(); sr_enter_req = 1'b0;
    check("R7 entry ignored hold", sr_hold, 0);
    check("R7 entry ignored req", ref_req, 0);
    check("R7 entry ignored stall", host_stall, 0);
    wait_req(); service(0);
    check("R6 sweep done", sweep_done, 1);
  endtask

  task automatic t_self_refresh();
    int n;
    do_reset();
    fill_sweep();
    sr_enter_req = 1'b1; tick(); sr_enter_req = 1'b0;
    check("R8 forced req", ref_req, 1);
    check("R8 no hold before bracket", sr_hold, 0);
    check("R5 stall on entry", host_stall, 1);
    service(0);
    check("R8 hold after bracket", sr_hold, 1);
    sr_exit_req = 1'b1;
    n = 0;
    for (int i = 0; i < 200 && sr_hold; i++) begin tick(); n++; end
    check("R9 hold length", n, SMIN);
    sr_exit_req = 1'b0;
    n = 0;
    for (int i = 0; i < 200 && !ref_req; i++) begin tick(); n++; end
    check("R10 precharge gap", n, SPRE);
    check("R10 stall during exit", host_stall, 1);
    service(0);
    check("R10 back to normal", host_stall, 0);
    check("R11 sweep cleared", sweep_done, 0);
    sr_enter_req = 1'b1; tick(); sr_enter_req = 1'b0;
    check("R11 reentry refused", host_stall, 0);
    n = 1;
    for (int i = 0; i < 200 && !ref_req; i++) begin tick(); n++; end
    check("R11 timer restart", n, INTV);
  endtask

  task automatic t_late_exit();
    do_reset();
    fill_sweep();
    sr_enter_req = 1'b1; tick(); sr_enter_req = 1'b0;
    service(0);
    repeat (SMIN + 15) tick();
    check("R9 hold kept without exit", sr_hold, 1);
    sr_exit_req = 1'b1; tick(); sr_exit_req = 1'b0;
    check("R9 late exit one cycle", sr_hold, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interval();
    t_strays();
    t_saturate();
    t_sweep();
    t_self_refresh();
    t_late_exit();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule